// File: doc/BRIEF.md
# PCM Serial Voice Port

This block connects a voice codec core to a time-slot PCM highway. An 8 kHz frame sync marks where each frame begins. At the start of a frame the port takes the encoder's word and sends it out serially, MSB first, on a data line that is enabled only during the slot. In the same slot it shifts in a word from the receive data line and hands it to the decoder as a parallel word with a one-cycle valid strobe. The slot always begins at the frame boundary, and the port uses one slot per frame.

The port runs on a fast reference clock (`clk`). It oversamples the master clock, the frame sync and the receive data through a common synchronizer, so all three carry the same delay. Three frame-sync formats choose which master-clock edge launches bits and which edge captures them, and whether the slot starts on the launch edge that sees frame sync or on the launch edge after it. A mode bit selects a 14-bit linear word or an 8-bit companded word.

The output enable follows a four-state controller with these states:
- `PS_DOWN`: powered down.
- `PS_ARM_FIRST`: powered, waiting for the first frame sync.
- `PS_ARM_SECOND`: waiting for the second frame sync.
- `PS_LIVE`: driving the highway.

The transitions are:
- DOWN→ARM_FIRST when power-up is requested and the master clock is present.
- ARM_FIRST→ARM_SECOND on a frame start.
- ARM_SECOND→LIVE on the next frame start.
- Any state→DOWN when power-up is removed or the master clock stops.

A watchdog counter on the reference clock declares the master clock lost after `LOSS_LIMIT` cycles with no edge on it.

Top module: `pcm_voice_port`

## Requirements
- R1: While reset is asserted and after it is released, `dx_oe` and `rx_valid` are 0 and `rx_word` is 0.
- R2: A frame start is a launch edge at which the synchronized `fsync` is 1 and was 0 at the previous launch edge. `fs_mode` codes 0 (non-delayed normal), 1 (delayed) and 3 (same as 0) launch bits on master-clock rising edges and capture `dr` on falling edges.
- R3: `fs_mode` code 2 (non-delayed reverse) launches bits on master-clock falling edges and captures `dr` on rising edges.
- R4: In codes 0, 2 and 3 the MSB appears at the launch edge that detects the frame start. In code 1 it appears at the following launch edge.
- R5: `lin_mode`=1 sends `tx_word[13:0]` and receives into `rx_word[13:0]`. `lin_mode`=0 sends `tx_word[7:0]` and receives into `rx_word[7:0]` with `rx_word[13:8]`=0. Both directions are MSB first, and each bit is held for one master-clock period.
- R6: `dx_oe` is 1 for exactly the word length in master-clock periods from the slot's first launch edge and is 0 at all other times. `dx` changes only at launch edges while enabled.
- R7: After the last bit of a slot is captured, `rx_word` is updated and `rx_valid` pulses for exactly one `clk` cycle. No pulse occurs while the port is powered down.
- R8: After `pwr_up` rises, the slot of the first frame start is received but not driven. The transmit output is first enabled in the slot of the second frame start.
- R9: With `pwr_up`=0, `dx_oe` is 0 from the next `clk` cycle on and no word is received.
- R10: If no master-clock edge is seen for `LOSS_LIMIT` `clk` cycles, the port powers down and a slot in progress is abandoned with `dx_oe` cleared. Once edges return, two frame starts are again needed before `dx_oe` is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, much faster than the master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mclk | input | 1 | Master (bit) clock of the PCM highway |
| fsync | input | 1 | 8 kHz frame sync |
| dr | input | 1 | Serial receive data |
| fs_mode | input | 2 | Frame-sync format: 0 normal, 1 delayed, 2 reverse, 3 as 0 |
| lin_mode | input | 1 | 1 = 14-bit linear word, 0 = 8-bit companded word |
| pwr_up | input | 1 | 1 requests power up, 0 powers down |
| tx_word | input | 14 | Encoder word, taken at slot start |
| dx | output | 1 | Serial transmit data |
| dx_oe | output | 1 | Transmit output enable; the pad is high impedance when 0 |
| rx_word | output | 14 | Last complete received word |
| rx_valid | output | 1 | One-cycle strobe when `rx_word` is updated |

## Verification
The bench builds the port with a two-stage synchronizer and `LOSS_LIMIT` = 40 reference cycles. It runs the master clock at one eighth of `clk`, so normal edges arrive every 4 cycles. This short limit makes it cheap to stop the clock for 60 cycles, once between frames and once inside a live slot, and to confirm the enable still holds after 20 cycles of silence. The same settings give every mode switch and both word lengths full frames of observation within a few thousand cycles, including the two-frame arming sequence after each power-up and each clock loss.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;

    typedef enum logic [1:0] {
        PS_DOWN       = 2'd0,
        PS_ARM_FIRST  = 2'd1,
        PS_ARM_SECOND = 2'd2,
        PS_LIVE       = 2'd3
    } port_state_t;

    typedef enum logic [1:0] {
        FS_NORMAL  = 2'd0,
        FS_DELAYED = 2'd1,
        FS_REVERSE = 2'd2,
        FS_SPARE   = 2'd3
    } fs_fmt_t;

endpackage

// File: rtl/pcm_in_sync.sv
module pcm_in_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] pipe [STAGES];

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_head
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) pipe[0] <= '0;
                    else        pipe[0] <= d;
                end
            end else begin : g_tail
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) pipe[i] <= '0;
                    else        pipe[i] <= pipe[i-1];
                end
            end
        end
    endgenerate

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/pcm_clk_watch.sv
module pcm_clk_watch #(
    parameter int LOSS_LIMIT = 256,
    localparam int CW = $clog2(LOSS_LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mclk_s,
    output logic rise,
    output logic fall,
    output logic lost
);
    logic          prev_q;
    logic [CW-1:0] idle_q;

    assign rise = mclk_s & ~prev_q;
    assign fall = ~mclk_s & prev_q;
    assign lost = (idle_q == CW'(LOSS_LIMIT));

    // Starts in the lost state: no edge has been seen yet.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            idle_q <= CW'(LOSS_LIMIT);
        end else begin
            prev_q <= mclk_s;
            if (rise || fall)  idle_q <= '0;
            else if (!lost)    idle_q <= idle_q + 1'b1;
        end
    end
endmodule

// File: rtl/pcm_slot_engine.sv
module pcm_slot_engine #(
    parameter int WORD_LIN = 14,
    parameter int WORD_CMP = 8,
    localparam int CNTW = $clog2(WORD_LIN + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                launch,
    input  logic                capture,
    input  logic                slot_go,
    input  logic                abort,
    input  logic                drive_ok,
    input  logic                lin_mode,
    input  logic [WORD_LIN-1:0] tx_word,
    input  logic                dr_s,
    output logic                dx,
    output logic                dx_oe,
    output logic [WORD_LIN-1:0] rx_word,
    output logic                rx_valid
);
    logic [WORD_LIN-1:0] tx_sr, rx_sr, rx_next;
    logic [CNTW-1:0]     tx_left, rx_left, word_len;
    logic                tx_on, tx_drive, rx_on;

    assign word_len = lin_mode ? CNTW'(WORD_LIN) : CNTW'(WORD_CMP);
    assign rx_next  = {rx_sr[WORD_LIN-2:0], dr_s};
    assign dx       = tx_sr[WORD_LIN-1];
    assign dx_oe    = tx_on & tx_drive;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sr    <= '0;
            tx_left  <= '0;
            tx_on    <= 1'b0;
            tx_drive <= 1'b0;
        end else if (abort) begin
            tx_on    <= 1'b0;
        end else if (slot_go) begin
            tx_sr    <= lin_mode ? tx_word
                                 : {tx_word[WORD_CMP-1:0], {(WORD_LIN-WORD_CMP){1'b0}}};
            tx_left  <= word_len - 1'b1;
            tx_on    <= 1'b1;
            tx_drive <= drive_ok;
        end else if (launch && tx_on) begin
            if (tx_left == '0) begin
                tx_on   <= 1'b0;
            end else begin
                tx_sr   <= {tx_sr[WORD_LIN-2:0], 1'b0};
                tx_left <= tx_left - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_sr    <= '0;
            rx_left  <= '0;
            rx_on    <= 1'b0;
            rx_word  <= '0;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (abort) begin
                rx_on   <= 1'b0;
            end else if (slot_go) begin
                rx_sr   <= '0;
                rx_left <= word_len;
                rx_on   <= 1'b1;
            end else if (capture && rx_on) begin
                rx_sr   <= rx_next;
                rx_left <= rx_left - 1'b1;
                if (rx_left == CNTW'(1)) begin
                    rx_on    <= 1'b0;
                    rx_word  <= rx_next;
                    rx_valid <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/pcm_voice_port.sv
module pcm_voice_port
    import pcm_port_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int LOSS_LIMIT  = 256,
    parameter int WORD_LIN    = 14,
    parameter int WORD_CMP    = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                mclk,
    input  logic                fsync,
    input  logic                dr,
    input  logic [1:0]          fs_mode,
    input  logic                lin_mode,
    input  logic                pwr_up,
    input  logic [WORD_LIN-1:0] tx_word,
    output logic                dx,
    output logic                dx_oe,
    output logic [WORD_LIN-1:0] rx_word,
    output logic                rx_valid
);
    logic [2:0]  raw_in, synced;
    logic        mclk_s, fs_s, dr_s;
    logic        m_rise, m_fall, clk_lost;
    logic        launch, capture, fs_evt, fs_prev, pend;
    logic        is_rev, is_dly, start_raw;
    logic        go_down, slot_go, drive_ok;
    fs_fmt_t     fmt;
    port_state_t state_q, state_d;

    assign raw_in = {mclk, fsync, dr};

    pcm_in_sync #(.STAGES(SYNC_STAGES), .WIDTH(3)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(raw_in), .q(synced)
    );

    assign mclk_s = synced[2];
    assign fs_s   = synced[1];
    assign dr_s   = synced[0];

    pcm_clk_watch #(.LOSS_LIMIT(LOSS_LIMIT)) u_watch (
        .clk(clk), .rst_n(rst_n), .mclk_s(mclk_s),
        .rise(m_rise), .fall(m_fall), .lost(clk_lost)
    );

    assign fmt     = fs_fmt_t'(fs_mode);
    assign is_rev  = (fmt == FS_REVERSE);
    assign is_dly  = (fmt == FS_DELAYED);
    assign launch  = is_rev ? m_fall : m_rise;
    assign capture = is_rev ? m_rise : m_fall;
    assign fs_evt  = launch && fs_s && !fs_prev;
    assign start_raw = is_dly ? (launch && pend) : fs_evt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fs_prev <= 1'b0;
            pend    <= 1'b0;
        end else if (launch) begin
            fs_prev <= fs_s;
            pend    <= fs_evt && is_dly;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PS_DOWN;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        if (!pwr_up || clk_lost) begin
            state_d = PS_DOWN;
        end else begin
            unique case (state_q)
                PS_DOWN:       state_d = PS_ARM_FIRST;
                PS_ARM_FIRST:  if (fs_evt) state_d = PS_ARM_SECOND;
                PS_ARM_SECOND: if (fs_evt) state_d = PS_LIVE;
                PS_LIVE:       state_d = PS_LIVE;
            endcase
        end
    end

    // Outputs of the controller
    always_comb begin
        go_down  = !pwr_up || clk_lost;
        slot_go  = start_raw && (state_q != PS_DOWN) && !go_down;
        drive_ok = (state_q == PS_LIVE) || ((state_q == PS_ARM_SECOND) && fs_evt);
    end

    pcm_slot_engine #(.WORD_LIN(WORD_LIN), .WORD_CMP(WORD_CMP)) u_slot (
        .clk(clk), .rst_n(rst_n),
        .launch(launch), .capture(capture),
        .slot_go(slot_go), .abort(go_down), .drive_ok(drive_ok),
        .lin_mode(lin_mode), .tx_word(tx_word), .dr_s(dr_s),
        .dx(dx), .dx_oe(dx_oe), .rx_word(rx_word), .rx_valid(rx_valid)
    );
endmodule

// File: rtl/pcm_voice_port_chk.sv
module pcm_voice_port_chk
    import pcm_port_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        pwr_up,
    input logic        launch,
    input logic        lost,
    input logic        dx,
    input logic        dx_oe,
    input logic        rx_valid,
    input port_state_t state
);
    // R2: the enable can only open at a launch edge
    a_r2_open_on_launch: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dx_oe) |-> $past(launch));

    // R6: data moves only at launch edges while enabled
    a_r6_data_on_launch: assert property (@(posedge clk) disable iff (!rst_n)
        (dx_oe && $past(dx_oe) && !$past(launch)) |-> $stable(dx));

    // R7: received-word strobe lasts one cycle
    a_r7_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R7: no strobe after power was removed
    a_r7_no_rx_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(pwr_up));

    // R8: the highway is driven only from the live state
    a_r8_drive_when_live: assert property (@(posedge clk) disable iff (!rst_n)
        dx_oe |-> (state == PS_LIVE));

    // R9: removing power silences the output
    a_r9_off_silences: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_up |=> !dx_oe);

    // R10: losing the master clock silences the output
    a_r10_loss_silences: assert property (@(posedge clk) disable iff (!rst_n)
        lost |=> !dx_oe);
endmodule

bind pcm_voice_port pcm_voice_port_chk u_chk (
    .clk(clk), .rst_n(rst_n), .pwr_up(pwr_up), .launch(launch),
    .lost(clk_lost), .dx(dx), .dx_oe(dx_oe), .rx_valid(rx_valid),
    .state(state_q)
);

// File: tb/pcm_voice_port_test.sv
module pcm_voice_port_test;
    localparam int HALF  = 4;
    localparam int LIMIT = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mclk = 1'b0, fsync = 1'b0, dr = 1'b1;
    logic [1:0]  fs_mode = 2'd0;
    logic        lin_mode = 1'b1, pwr_up = 1'b0;
    logic [13:0] tx_word = '0;
    logic        dx, dx_oe, rx_valid;
    logic [13:0] rx_word;

    always #10 clk = ~clk;   // 50 MHz

    pcm_voice_port #(.SYNC_STAGES(2), .LOSS_LIMIT(LIMIT)) uut (
        .clk(clk), .rst_n(rst_n), .mclk(mclk), .fsync(fsync), .dr(dr),
        .fs_mode(fs_mode), .lin_mode(lin_mode), .pwr_up(pwr_up),
        .tx_word(tx_word), .dx(dx), .dx_oe(dx_oe),
        .rx_word(rx_word), .rx_valid(rx_valid)
    );

    typedef struct {
        bit    oe;
        bit    val;
        string tag;
    } exp_t;

    exp_t        bit_q[$];
    logic [13:0] rx_q[$];
    int          checks = 0, errors = 0;
    event        sample_ev;

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, expv);
        end
    endtask

    // Monitor: one expectation per capture edge
    initial begin
        exp_t e;
        forever begin
            @(sample_ev);
            if (bit_q.size() == 0) begin
                check(1'b0, "R6", "capture with no expectation", 0, 1);
            end else begin
                e = bit_q.pop_front();
                if (e.oe) begin
                    check(dx_oe === 1'b1, e.tag, "enable", int'(dx_oe), 1);
                    check(dx === e.val, e.tag, "data bit", int'(dx), int'(e.val));
                end else begin
                    check(dx_oe === 1'b0, e.tag, "enable off", int'(dx_oe), 0);
                end
            end
        end
    end

    // Monitor: received words
    always @(negedge clk) begin
        if (rst_n && rx_valid) begin
            if (rx_q.size() == 0) begin
                check(1'b0, "R7", "unexpected receive strobe", int'(rx_word), 0);
            end else begin
                logic [13:0] w;
                w = rx_q.pop_front();
                check(rx_word === w, "R7", "received word", int'(rx_word), int'(w));
            end
        end
    end

    // Driver: one frame of master-clock periods
    task automatic run_frame(input int mode, input bit lin, input logic [13:0] txw,
                             input logic [13:0] rxw, input bit drive, input bit rx_exp,
                             input int stall_at, input string tag);
        int   len   = lin ? 14 : 8;
        int   first = (mode == 1) ? 2 : 1;
        int   total = first + len + 2;
        logic lvl   = (mode == 2) ? 1'b0 : 1'b1;
        bit   aborted = 1'b0;
        fs_mode  = 2'(mode);
        lin_mode = lin;
        tx_word  = txw;
        if (rx_exp) rx_q.push_back(lin ? rxw : {6'b0, rxw[7:0]});
        for (int p = 0; p < total; p++) begin
            bit   in_slot = (p >= first) && (p < first + len);
            exp_t e;
            if (p == stall_at) begin
                repeat (20) @(negedge clk);
                check(dx_oe === drive, "R10", "enable before limit", int'(dx_oe), int'(drive));
                repeat (40) @(negedge clk);
                check(dx_oe === 1'b0, "R10", "enable after clock loss", int'(dx_oe), 0);
                aborted = 1'b1;
            end
            mclk = lvl;
            dr   = in_slot ? rxw[len-1-(p-first)] : 1'b1;
            repeat (HALF) @(negedge clk);
            e.oe  = drive && in_slot && !aborted;
            e.val = in_slot ? txw[len-1-(p-first)] : 1'b0;
            if (aborted)              e.tag = "R10";
            else if (!in_slot)        e.tag = "R6";
            else if (!drive)          e.tag = tag;
            else if (p == first)      e.tag = "R4";
            else                      e.tag = (mode == 2) ? "R3" : "R5";
            bit_q.push_back(e);
            -> sample_ev;
            mclk  = ~lvl;
            fsync = (p == 0);
            repeat (HALF) @(negedge clk);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(dx_oe === 1'b0, "R1", "enable in reset", int'(dx_oe), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(dx_oe === 1'b0 && rx_valid === 1'b0, "R1", "outputs after reset",
              int'({dx_oe, rx_valid}), 0);
        check(rx_word === 14'h0, "R1", "rx word after reset", int'(rx_word), 0);

        // Powered down: nothing driven, nothing received
        run_frame(0, 1, 14'h2A5C, 14'h1337, 0, 0, -1, "R9");
        pwr_up = 1'b1;
        run_frame(0, 1, 14'h3001, 14'h0ABC, 0, 1, -1, "R8");   // first frame: silent
        run_frame(0, 1, 14'h2D96, 14'h3F0F, 1, 1, -1, "R2");   // second: driven
        run_frame(3, 1, 14'h0F3C, 14'h2222, 1, 1, -1, "R2");
        run_frame(0, 0, 14'h15A5, 14'h00C3, 1, 1, -1, "R5");
        run_frame(1, 1, 14'h1E1E, 14'h2BCD, 1, 1, -1, "R4");
        run_frame(1, 0, 14'h3F81, 14'h0199, 1, 1, -1, "R4");
        run_frame(2, 1, 14'h2AAA, 14'h1555, 1, 1, -1, "R3");
        run_frame(2, 0, 14'h007E, 14'h3F42, 1, 1, -1, "R3");

        // Power cycle
        pwr_up = 1'b0;
        run_frame(0, 1, 14'h1234, 14'h0F0F, 0, 0, -1, "R9");
        pwr_up = 1'b1;
        run_frame(0, 1, 14'h2345, 14'h1111, 0, 1, -1, "R8");
        run_frame(0, 1, 14'h3456, 14'h2468, 1, 1, -1, "R8");

        // Clock loss between frames
        repeat (60) @(negedge clk);
        run_frame(0, 1, 14'h0555, 14'h3333, 0, 1, -1, "R10");
        run_frame(0, 1, 14'h3AAA, 14'h0777, 1, 1, -1, "R10");

        // Clock loss inside a live slot
        run_frame(0, 1, 14'h2F0F, 14'h1A1A, 1, 0, 4, "R10");
        run_frame(0, 1, 14'h1C1C, 14'h2B2B, 0, 1, -1, "R10");
        run_frame(0, 1, 14'h0E0E, 14'h3C3C, 1, 1, -1, "R10");

        repeat (10) @(negedge clk);
        check(rx_q.size() == 0, "R7", "received words outstanding", rx_q.size(), 0);
        check(bit_q.size() == 0, "R6", "captures outstanding", bit_q.size(), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "R6", "watchdog expired", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule